// File: doc/BRIEF.md
# Camera Receiver Bring-up Sequencer

This block is a hardware state machine that powers up a serial camera receiver and its D-PHY in a fixed order, so that no software has to poll status words. A start command with a lane count starts the run. The machine then does the following, in order:

1. Issues a PHY configuration strobe.
2. Latches the lane-count field and releases the PHY shutdown, the PHY reset and the receiver reset together. At the same moment it asks the sensor to hold its lanes in low power.
3. Waits for the stop state on the clock lane and on every active data lane.
4. Asks the sensor to start streaming.
5. Waits until the clock lane carries a high-speed clock.

Every wait has a cycle-count timeout. A stop-state timeout only raises a warning, and the run goes on. A timeout on a sensor acknowledge or on the high-speed clock is fatal. In that case the machine unwinds the steps already taken, in reverse order, and returns to idle with the error flag set. When it reaches the running state, a one-cycle done pulse is issued. A stop command in the running state shuts the sensor down first and drops the three enables last.

Top module: `csi_bringup_seq`

## Requirements
- R1: Out of reset the lane field is 0, the three enables are 0, all strobes are 0, and done, warning and error are 0.
- R2: An accepted start latches lane_cfg_o = lanes_i - 1. A start with lanes_i of 0 or above MAX_LANES sets err_o in the next cycle and changes neither lane_cfg_o nor the enables. Any accepted start clears err_o and warn_o.
- R3: After an accepted start the sequence runs in this order:
  - phy_cfg_o for one cycle, with the enables still 0;
  - all three enables go to 1, together with a one-cycle sensor_lp_hold_o;
  - a wait for sensor_ack_i;
  - the stop-state wait;
  - a one-cycle sensor_stream_on_o;
  - a wait for sensor_ack_i;
  - a wait for the high-speed clock flag at phy_state_i bit 8.

  With every condition already true, done_o appears 7 cycles after phy_cfg_o.
- R4: The stop-state wait passes only when phy_state_i bit 10 (clock lane stop) and bits 4 to 4+N-1 are all set, where N is the latched lane count. All other bits of phy_state_i, including bit 9, have no effect on this wait.
- R5: If the stop-state wait times out, warn_o is set and the sequence goes on to sensor_stream_on_o.
- R6: If the high-speed clock wait times out, err_o is set. The block then issues sensor_stream_off_o, then sensor_lp_release_o in the next cycle, and drives the enables to 0 in the cycle after that.
- R7: A sensor acknowledge timeout sets err_o and unwinds through sensor_lp_release_o only, with no sensor_stream_off_o, and then drives the enables to 0.
- R8: done_o is a one-cycle pulse issued when the running state is entered.
- R9: stop_i in the running state gives sensor_stream_off_o, then sensor_lp_release_o, then enables at 0, one step per cycle. stop_i in any other state has no effect.
- R10: start_i while a sequence is in progress or running has no effect on lane_cfg_o, the strobes or done_o.
- R11: Each wait lasts at most TIMEOUT_CYC cycles. The block leaves the wait on the clock edge that ends its TIMEOUT_CYC-th cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start the bring-up sequence |
| stop_i | input | 1 | Shut down from the running state |
| lanes_i | input | LANE_W | Requested number of data lanes |
| phy_state_i | input | 16 | PHY status word |
| sensor_ack_i | input | 1 | Sensor acknowledge for low-power hold and stream start |
| lane_cfg_o | output | CFG_W | Active lanes minus one |
| phy_shutdown_n_o | output | 1 | PHY shutdown control, 1 = enabled |
| phy_rst_n_o | output | 1 | PHY reset control, 1 = released |
| rx_rst_n_o | output | 1 | Receiver reset control, 1 = released |
| phy_cfg_o | output | 1 | PHY configuration strobe |
| sensor_lp_hold_o | output | 1 | Ask the sensor to hold its lanes in low power |
| sensor_stream_on_o | output | 1 | Ask the sensor to start its clock and stream |
| sensor_stream_off_o | output | 1 | Ask the sensor to stop streaming |
| sensor_lp_release_o | output | 1 | Release the sensor low-power hold |
| done_o | output | 1 | One-cycle pulse on reaching the running state |
| warn_o | output | 1 | Sticky stop-state timeout warning |
| err_o | output | 1 | Sticky fatal error |

## Verification
The bench checks status words where one lane's stop bit or the clock stop bit is missing, and words with the ultra-low-power bit set. A mask built with the wrong lane count or the wrong shift would raise the warning wrongly or miss it.

Each of the three fatal timeouts is checked, and so is the unwind order it must follow. An unwind that issues a stream-off after a failed stream start, or that drops the enables before the releases, shows up as a strobe at the wrong cycle.

Timeout lengths are checked to the exact cycle, which catches an off-by-one in the counter. Starts that arrive while busy, while running, or with lane count 0 or 5 are checked for leaving the lane field and the enables unchanged.

// File: rtl/csi_bringup_pkg.sv
package csi_bringup_pkg;
  localparam int unsigned STAT_W        = 16;
  localparam int unsigned DATA_STOP_LSB = 4;
  localparam int unsigned HS_CLK_BIT    = 8;
  localparam int unsigned CLK_STOP_BIT  = 10;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PHYCFG,
    ST_ENABLE,
    ST_WT_LP,
    ST_WT_STOP,
    ST_CLKREQ,
    ST_WT_STRM,
    ST_WT_HS,
    ST_RUN,
    ST_UN_STRM,
    ST_UN_LP
  } seq_state_e;
endpackage

// File: rtl/bringup_timer.sv
module bringup_timer #(
  parameter int unsigned LIMIT = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (run_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST) else $error("timer overrun"); // R11
endmodule

// File: rtl/phy_status_eval.sv
module phy_status_eval import csi_bringup_pkg::*; #(
  parameter int unsigned MAX_LANES = 4,
  parameter int unsigned CFG_W     = 2
) (
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [STAT_W-1:0] phy_state_i,
  output logic              stop_ok_o,
  output logic              hs_ok_o
);
  logic [MAX_LANES-1:0] lane_bits;
  logic [STAT_W-1:0]    mask;

  for (genvar n = 0; n < MAX_LANES; n++) begin : g_lane
    assign lane_bits[n] = (cfg_i >= CFG_W'(n));
  end

  assign mask      = (STAT_W'(lane_bits) << DATA_STOP_LSB) | (STAT_W'(1) << CLK_STOP_BIT);
  assign stop_ok_o = ((phy_state_i & mask) == mask);
  assign hs_ok_o   = phy_state_i[HS_CLK_BIT];
endmodule

// File: rtl/bringup_fsm.sv
module bringup_fsm import csi_bringup_pkg::*; #(
  parameter int unsigned MAX_LANES = 4,
  parameter int unsigned LANE_W    = 3,
  parameter int unsigned CFG_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [LANE_W-1:0] lanes_i,
  input  logic              stop_ok_i,
  input  logic              hs_ok_i,
  input  logic              ack_i,
  input  logic              tmo_i,
  output logic              wait_o,
  output logic              step_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              phy_cfg_o,
  output logic              en_o,
  output logic              lp_hold_o,
  output logic              strm_on_o,
  output logic              strm_off_o,
  output logic              lp_rel_o,
  output logic              done_o,
  output logic              warn_o,
  output logic              err_o
);
  seq_state_e       state_q, state_d;
  logic [CFG_W-1:0] cfg_q;
  logic             done_q, warn_q, err_q;
  logic             lanes_ok, start_ok, start_bad;
  logic             fatal_tmo, stop_tmo;

  assign lanes_ok  = (lanes_i != '0) && (lanes_i <= LANE_W'(MAX_LANES));
  assign start_ok  = (state_q == ST_IDLE) && start_i && lanes_ok;
  assign start_bad = (state_q == ST_IDLE) && start_i && !lanes_ok;

  always_comb begin
    state_d   = state_q;
    fatal_tmo = 1'b0;
    stop_tmo  = 1'b0;
    unique case (state_q)
      ST_IDLE:    if (start_ok) state_d = ST_PHYCFG;
      ST_PHYCFG:  state_d = ST_ENABLE;
      ST_ENABLE:  state_d = ST_WT_LP;
      ST_WT_LP: begin
        if (ack_i) state_d = ST_WT_STOP;
        else if (tmo_i) begin
          state_d   = ST_UN_LP;
          fatal_tmo = 1'b1;
        end
      end
      ST_WT_STOP: begin
        if (stop_ok_i) state_d = ST_CLKREQ;
        else if (tmo_i) begin
          state_d  = ST_CLKREQ;  // warn and continue
          stop_tmo = 1'b1;
        end
      end
      ST_CLKREQ:  state_d = ST_WT_STRM;
      ST_WT_STRM: begin
        if (ack_i) state_d = ST_WT_HS;
        else if (tmo_i) begin
          state_d   = ST_UN_LP;  // sensor never streamed: skip stream-off
          fatal_tmo = 1'b1;
        end
      end
      ST_WT_HS: begin
        if (hs_ok_i) state_d = ST_RUN;
        else if (tmo_i) begin
          state_d   = ST_UN_STRM;
          fatal_tmo = 1'b1;
        end
      end
      ST_RUN:     if (stop_i) state_d = ST_UN_STRM;
      ST_UN_STRM: state_d = ST_UN_LP;
      ST_UN_LP:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      done_q  <= 1'b0;
      warn_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_WT_HS) && (state_d == ST_RUN);
      if (start_ok) begin
        cfg_q  <= CFG_W'(lanes_i - LANE_W'(1));
        warn_q <= 1'b0;
        err_q  <= 1'b0;
      end else begin
        if (start_bad || fatal_tmo) err_q  <= 1'b1;
        if (stop_tmo)               warn_q <= 1'b1;
      end
    end
  end

  assign wait_o     = state_q inside {ST_WT_LP, ST_WT_STOP, ST_WT_STRM, ST_WT_HS};
  assign step_o     = (state_d != state_q);
  assign cfg_o      = cfg_q;
  assign phy_cfg_o  = (state_q == ST_PHYCFG);
  assign en_o       = !(state_q inside {ST_IDLE, ST_PHYCFG});
  assign lp_hold_o  = (state_q == ST_ENABLE);
  assign strm_on_o  = (state_q == ST_CLKREQ);
  assign strm_off_o = (state_q == ST_UN_STRM);
  assign lp_rel_o   = (state_q == ST_UN_LP);
  assign done_o     = done_q;
  assign warn_o     = warn_q;
  assign err_o      = err_q;

  AST_DONE_NEEDS_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(hs_ok_i)) else $error("done without clock"); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q) else $error("done too long"); // R8
  AST_WARN_FROM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warn_q) |-> $past(state_q == ST_WT_STOP)) else $error("stray warn"); // R5
  AST_OFF_THEN_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strm_off_o |=> lp_rel_o) else $error("unwind order"); // R9
  AST_EN_DROP_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_o) |-> $past(lp_rel_o)) else $error("enables dropped early"); // R6
  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) && $past(state_q != ST_IDLE) |-> $stable(cfg_q))
    else $error("lane field moved while busy"); // R10
endmodule

// File: rtl/csi_bringup_seq.sv
module csi_bringup_seq import csi_bringup_pkg::*; #(
  parameter int unsigned MAX_LANES   = 4,
  parameter int unsigned CLK_HZ      = 250_000_000,
  parameter int unsigned TIMEOUT_MS  = 500,
  parameter int unsigned TIMEOUT_CYC = CLK_HZ / 1000 * TIMEOUT_MS,
  localparam int unsigned LANE_W     = $clog2(MAX_LANES + 1),
  localparam int unsigned CFG_W      = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [LANE_W-1:0] lanes_i,
  input  logic [STAT_W-1:0] phy_state_i,
  input  logic              sensor_ack_i,
  output logic [CFG_W-1:0]  lane_cfg_o,
  output logic              phy_shutdown_n_o,
  output logic              phy_rst_n_o,
  output logic              rx_rst_n_o,
  output logic              phy_cfg_o,
  output logic              sensor_lp_hold_o,
  output logic              sensor_stream_on_o,
  output logic              sensor_stream_off_o,
  output logic              sensor_lp_release_o,
  output logic              done_o,
  output logic              warn_o,
  output logic              err_o
);
  logic stop_ok, hs_ok, tmo, wait_st, step, en;

  phy_status_eval #(.MAX_LANES(MAX_LANES), .CFG_W(CFG_W)) u_eval (
    .cfg_i       (lane_cfg_o),
    .phy_state_i (phy_state_i),
    .stop_ok_o   (stop_ok),
    .hs_ok_o     (hs_ok)
  );

  bringup_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (wait_st),
    .clr_i     (step),
    .expired_o (tmo)
  );

  bringup_fsm #(.MAX_LANES(MAX_LANES), .LANE_W(LANE_W), .CFG_W(CFG_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .lanes_i    (lanes_i),
    .stop_ok_i  (stop_ok),
    .hs_ok_i    (hs_ok),
    .ack_i      (sensor_ack_i),
    .tmo_i      (tmo),
    .wait_o     (wait_st),
    .step_o     (step),
    .cfg_o      (lane_cfg_o),
    .phy_cfg_o  (phy_cfg_o),
    .en_o       (en),
    .lp_hold_o  (sensor_lp_hold_o),
    .strm_on_o  (sensor_stream_on_o),
    .strm_off_o (sensor_stream_off_o),
    .lp_rel_o   (sensor_lp_release_o),
    .done_o     (done_o),
    .warn_o     (warn_o),
    .err_o      (err_o)
  );

  assign phy_shutdown_n_o = en;
  assign phy_rst_n_o      = en;
  assign rx_rst_n_o       = en;
endmodule

// File: tb/sim_csi_bringup_seq.sv
module sim_csi_bringup_seq;
  localparam int TMO = 20;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, sensor_ack_i = 1'b0;
  logic [2:0]  lanes_i = 3'd1;
  logic [15:0] phy_state_i = 16'h0;
  logic [1:0]  lane_cfg_o;
  logic        phy_shutdown_n_o, phy_rst_n_o, rx_rst_n_o, phy_cfg_o;
  logic        sensor_lp_hold_o, sensor_stream_on_o, sensor_stream_off_o, sensor_lp_release_o;
  logic        done_o, warn_o, err_o;

  int tests = 0, fails = 0;

  always #2 clk_i = ~clk_i;

  csi_bringup_seq #(.MAX_LANES(4), .TIMEOUT_CYC(TMO)) u0 (.*);

  typedef struct packed {
    logic [2:0]  ln;
    logic [15:0] ph;
    logic        wr;
  } vec_t;

  // lane count, status word, expected warning (bit10 clk stop, bits 4.. data stop, bit8 hs)
  localparam vec_t VEC [8] = '{
    '{3'd1, 16'h0510, 1'b0},
    '{3'd2, 16'h0510, 1'b1},
    '{3'd2, 16'h0530, 1'b0},
    '{3'd4, 16'h05F0, 1'b0},
    '{3'd4, 16'h0570, 1'b1},
    '{3'd3, 16'h0170, 1'b1},
    '{3'd1, 16'h05E0, 1'b1},
    '{3'd3, 16'h0770, 1'b0}
  };

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  function automatic int en3();
    return {phy_shutdown_n_o, phy_rst_n_o, rx_rst_n_o};
  endfunction

  task automatic do_start(int ln);
    step();
    start_i = 1'b1;
    lanes_i = 3'(ln);
    step();
    start_i = 1'b0;
  endtask

  task automatic do_stop();
    step();
    stop_i = 1'b1;
    step();
    stop_i = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 6; i++) step();
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int t_off, t_rel, t_on, t_cfg;
    int seen_done;
    repeat (3) step();
    // R1 reset state
    chk("R1 enables", en3(), 0);
    chk("R1 lane field", lane_cfg_o, 0);
    chk("R1 strobes", {phy_cfg_o, sensor_lp_hold_o, sensor_stream_on_o,
                       sensor_stream_off_o, sensor_lp_release_o}, 0);
    chk("R1 flags", {done_o, warn_o, err_o}, 0);
    rst_ni = 1'b1;
    step();

    // vector table: mask behaviour per lane count
    for (int v = 0; v < 8; v++) begin
      sensor_ack_i = 1'b1;
      phy_state_i  = VEC[v].ph;
      do_start(VEC[v].ln);
      seen_done = 0;
      for (int i = 0; i < 60; i++) begin
        if (done_o) begin seen_done = 1; break; end
        step();
      end
      chk("R3 vector reaches run", seen_done, 1);
      chk("R2 vector lane field", lane_cfg_o, VEC[v].ln - 1);
      chk("R4 R5 vector warning", warn_o, VEC[v].wr);
      chk("R3 vector no error", err_o, 0);
      do_stop();
      step(); step();
      chk("R9 vector enables off", en3(), 0);
      settle();
    end

    // exact order with all conditions met
    sensor_ack_i = 1'b1;
    phy_state_i  = 16'h0530;
    do_start(2);
    chk("R3 phy cfg first", phy_cfg_o, 1);
    chk("R3 enables held during cfg", en3(), 0);
    step();
    chk("R3 enables on", en3(), 7);
    chk("R3 lp hold strobe", sensor_lp_hold_o, 1);
    step(); step(); step();
    chk("R3 stream on strobe", sensor_stream_on_o, 1);
    step(); step();
    chk("R8 no early done", done_o, 0);
    step();
    chk("R8 done pulse", done_o, 1);
    step();
    chk("R8 done one cycle", done_o, 0);
    // start while running
    do_start(4);
    chk("R10 no cfg strobe when running", phy_cfg_o, 0);
    settle();
    chk("R10 lane field kept when running", lane_cfg_o, 1);
    chk("R10 no second done", done_o, 0);
    // stop order
    do_stop();
    chk("R9 stream off first", sensor_stream_off_o, 1);
    chk("R9 enables during stream off", en3(), 7);
    step();
    chk("R9 lp release second", sensor_lp_release_o, 1);
    chk("R9 enables during release", en3(), 7);
    step();
    chk("R9 enables off last", en3(), 0);
    // stop in idle
    do_stop();
    chk("R9 stop in idle ignored", {sensor_stream_off_o, sensor_lp_release_o}, 0);
    step();
    chk("R9 stop in idle ignored later", {sensor_stream_off_o, sensor_lp_release_o}, 0);
    settle();

    // stop-state timeout timing
    phy_state_i = 16'h0510;
    do_start(2);
    t_on = 0;
    for (int n = 2; n < 40; n++) begin
      step();
      if (sensor_stream_on_o && t_on == 0) t_on = n;
    end
    chk("R11 stop wait length", t_on, 4 + TMO);
    chk("R5 warning set", warn_o, 1);
    do_stop();
    settle();

    // low-power ack timeout, with a busy start in the middle
    sensor_ack_i = 1'b0;
    do_start(1);
    t_rel = 0; t_on = 0; t_cfg = 0;
    for (int n = 2; n < 40; n++) begin
      step();
      if (n == 5) begin start_i = 1'b1; lanes_i = 3'd3; end
      if (n == 6) start_i = 1'b0;
      if (sensor_lp_release_o && t_rel == 0) t_rel = n;
      if (sensor_stream_on_o) t_on = n;
      if (phy_cfg_o) t_cfg = n;
    end
    chk("R7 lp ack timeout release", t_rel, 3 + TMO);
    chk("R7 no stream on", t_on, 0);
    chk("R7 error set", err_o, 1);
    chk("R7 enables off", en3(), 0);
    chk("R10 busy start no cfg strobe", t_cfg, 0);
    chk("R10 busy start lane field", lane_cfg_o, 0);

    // stream ack timeout
    sensor_ack_i = 1'b1;
    phy_state_i  = 16'h0510;
    do_start(1);
    t_rel = 0; t_off = 0;
    for (int n = 2; n < 40; n++) begin
      step();
      if (n == 4) sensor_ack_i = 1'b0;
      if (sensor_lp_release_o && t_rel == 0) t_rel = n;
      if (sensor_stream_off_o) t_off = n;
    end
    chk("R7 stream ack timeout release", t_rel, 6 + TMO);
    chk("R7 no stream off", t_off, 0);
    chk("R7 stream ack error", err_o, 1);
    chk("R5 no warning", warn_o, 0);

    // high-speed clock timeout
    sensor_ack_i = 1'b1;
    phy_state_i  = 16'h0410;
    do_start(1);
    t_rel = 0; t_off = 0;
    for (int n = 2; n < 40; n++) begin
      step();
      if (sensor_lp_release_o && t_rel == 0) t_rel = n;
      if (sensor_stream_off_o && t_off == 0) t_off = n;
      if (n == 9 + TMO) chk("R6 enables off after release", en3(), 0);
      if (n == 8 + TMO) chk("R6 enables on during release", en3(), 7);
    end
    chk("R6 stream off time", t_off, 7 + TMO);
    chk("R6 release time", t_rel, 8 + TMO);
    chk("R6 error set", err_o, 1);
    chk("R8 no done on failure", done_o, 0);

    // bad lane counts
    phy_state_i = 16'h0530;
    do_start(2);
    settle(); settle();
    do_stop();
    settle();
    do_start(5);
    chk("R2 too many lanes error", err_o, 1);
    chk("R2 lane field kept", lane_cfg_o, 1);
    chk("R2 no cfg strobe", phy_cfg_o, 0);
    step();
    chk("R2 enables stay off", en3(), 0);
    do_start(0);
    chk("R2 zero lanes error", err_o, 1);
    chk("R2 zero lanes field kept", lane_cfg_o, 1);
    do_start(3);
    chk("R2 good start clears error", err_o, 0);
    chk("R2 good start lane field", lane_cfg_o, 2);
    settle(); settle();
    do_stop();
    settle();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule